// File: doc/BRIEF.md
# SMBus Slave Read/Write Protocol Engine

This block is a synchronous SMBus slave that runs entirely on a fast system clock. It oversamples the SCL and SDA lines, finds START, REPEATED START and STOP conditions, and answers to a single 7-bit device address. It drives SDA only through an open-drain enable: when `sda_oe` is high the pad pulls the line low, and otherwise the line floats high. Clock stretching, PEC and multi-master arbitration are not part of the block.

A host writes a command byte and then data bytes into a small register file. To read, the host writes the command byte, issues a REPEATED START, and readdresses the slave with the read bit set. The slave then sends either a 16-bit word, low byte first, or a count-prefixed block that holds the bytes of every word register.

Two more features protect the bus and the register contents. A configurable inactivity watchdog releases SDA if the bus goes quiet in the middle of a transfer. A sticky lock bit, once set, keeps the critical registers from being changed until the next reset.

Top module: `smb_slave_engine`

## Requirements
- R1: A START or REPEATED START always restarts address reception, and a STOP returns the slave to idle. An address byte whose upper 7 bits equal `DEV_ADDR` (default 0x40) is acknowledged by pulling SDA low on the ninth clock. Any other address is not acknowledged, and the slave then stays silent until the next START.
- R2: A write is the address with bit 0 = 0, then a command byte, then data bytes. Every byte is acknowledged. For commands 0 to `NREG`-1, the first data byte is written to bit 7:0 of that word register and the second data byte to bit 15:8.
- R3: A read is the write-addressed command, then a REPEATED START, then the address with bit 0 = 1. For a word command, the slave sends bit 7:0 first and bit 15:8 second.
- R4: When the master answers a transmitted byte with NACK (SDA high on the ninth clock), the slave releases SDA and drives nothing more until the next START.
- R5: A read of command `CMD_BLK` (0x30) returns a count byte equal to 2*`NREG` (8 by default). It then returns the word registers from index 0 upward, each one as its low byte followed by its high byte.
- R6: Configuration register `CMD_CFG` (0xD1) is 8 bits wide, and its bit 3 enables the inactivity timeout. When enabled, if SCL and SDA show no edge for `CLK_KHZ`*`TIMEOUT_MS` system clocks during a transfer, the slave releases SDA and goes idle. When the bit is clear, the slave keeps its state.
- R7: Bit 0 of the lock register `CMD_LOCK` (0xD0) reads back as the lock state. Writing 1 sets the lock. Writing 0 does not clear it; only reset clears it.
- R8: While the lock is set, writes to the word registers selected by `CRIT_MASK` (default indices 2 and 3) are still acknowledged, but their data is discarded. The other word registers stay writable.
- R9: Any byte read past the defined data of a command returns 0xFF. For a word command that is index 2 and above; for the block command it is index 2*`NREG`+1 and above. The high byte of the configuration and lock registers reads as 0x00.
- R10: After reset, SDA is released, all word registers and the configuration register are zero, the timeout is disabled, and the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset (power-on) |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level (the wired value) |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench targets several corner cases, each paired with the failure it would catch:
- A read of three bytes from a word register checks that the third byte is the 0xFF filler. A design whose byte index wraps or repeats would return register data there instead.
- A block read that the master NACKs after two bytes is followed by a byte whose top bit is 0. If the slave kept transmitting after the NACK, it would visibly pull SDA low.
- The timeout is stalled with the slave holding its acknowledge low, once with the timeout disabled and once with it enabled. A reversed enable, or a counter that never fires, shows up as the wrong `sda_oe` level.
- After the lock is set, the bench writes 0 to the lock register and writes to a critical and a non-critical register. A clearable lock or an unconditional write shows up on read-back.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } smb_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_DATA
  } smb_kind_e;

  function automatic logic addr_match(input logic [7:0] rx, input logic [6:0] dev);
    return rx[7:1] == dev;
  endfunction

  function automatic logic [7:0] word_byte(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [7:0] idx_next(input logic [7:0] idx);
    return (idx == 8'hFF) ? idx : idx + 8'd1;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic any_edge
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign any_edge  = (scl_s ^ scl_p) | (sda_s ^ sda_p);

endmodule

// File: rtl/smb_timeout.sv
module smb_timeout #(
  parameter int unsigned TO_CYC = 3500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic busy,
  input  logic activity,
  output logic hit
);

  localparam int CW = $clog2(TO_CYC + 1);

  logic [CW-1:0] cnt;

  assign hit = en && busy && !activity && (cnt == CW'(TO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (!en || !busy || activity || hit) cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end

  AST_TO_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R6

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile import smb_pkg::*; #(
  parameter int NREG = 4,
  parameter logic [NREG-1:0] CRIT_MASK = NREG'(4'b1100),
  parameter logic [7:0] CMD_CFG  = 8'hD1,
  parameter logic [7:0] CMD_LOCK = 8'hD0,
  parameter logic [7:0] CMD_BLK  = 8'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wcmd,
  input  logic [7:0] widx,
  input  logic [7:0] wdata,
  input  logic [7:0] rcmd,
  input  logic [7:0] ridx,
  output logic [7:0] rd_byte,
  output logic       to_en
);

  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] BLK_LEN = 8'(2 * NREG);

  logic [15:0] words [NREG];
  logic [NREG*16-1:0] words_flat;
  logic [7:0] cfg;
  logic lock_q;
  logic wr_word, wr_blocked;
  logic [AW:0] bi;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign words_flat[g*16 +: 16] = words[g];
  end

  assign wr_word    = we && (widx < 8'd2) && (wcmd < 8'(NREG));
  assign wr_blocked = wr_word && lock_q && CRIT_MASK[wcmd[AW-1:0]];
  assign to_en      = cfg[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) words[i] <= '0;
      cfg    <= '0;
      lock_q <= 1'b0;
    end else if (we) begin
      if (wr_word && !wr_blocked) begin
        if (widx[0]) words[wcmd[AW-1:0]][15:8] <= wdata;
        else         words[wcmd[AW-1:0]][7:0]  <= wdata;
      end
      if (wcmd == CMD_CFG && widx == 8'd0)  cfg    <= wdata;
      if (wcmd == CMD_LOCK && widx == 8'd0) lock_q <= lock_q | wdata[0];
    end
  end

  assign bi = ridx[AW:0] - 1'b1;

  always_comb begin
    rd_byte = 8'hFF;
    if (rcmd < 8'(NREG)) begin
      if (ridx < 8'd2) rd_byte = word_byte(words[rcmd[AW-1:0]], ridx[0]);
    end else if (rcmd == CMD_CFG) begin
      if (ridx == 8'd0)      rd_byte = cfg;
      else if (ridx == 8'd1) rd_byte = 8'h00;
    end else if (rcmd == CMD_LOCK) begin
      if (ridx == 8'd0)      rd_byte = {7'd0, lock_q};
      else if (ridx == 8'd1) rd_byte = 8'h00;
    end else if (rcmd == CMD_BLK) begin
      if (ridx == 8'd0)          rd_byte = BLK_LEN;
      else if (ridx <= BLK_LEN)  rd_byte = word_byte(words[bi[AW:1]], bi[0]);
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R7

  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(words_flat)); // R8

endmodule

// File: rtl/smb_slave_engine.sv
module smb_slave_engine import smb_pkg::*; #(
  parameter logic [6:0]  DEV_ADDR   = 7'h40,
  parameter int          NREG       = 4,
  parameter logic [NREG-1:0] CRIT_MASK = NREG'(4'b1100),
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned TIMEOUT_MS = 35,
  parameter logic [7:0]  CMD_CFG    = 8'hD1,
  parameter logic [7:0]  CMD_LOCK   = 8'hD0,
  parameter logic [7:0]  CMD_BLK    = 8'h30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);

  localparam int unsigned TO_CYC = CLK_KHZ * TIMEOUT_MS;

  // bus events
  logic sda_s, scl_rise, scl_fall, start_det, stop_det, any_edge;
  logic to_hit, to_en;

  // protocol state
  smb_state_e state;
  smb_kind_e  kind;
  logic [7:0] sh;
  logic [6:0] tx_sh;
  logic [3:0] bcnt;
  logic [7:0] cmd_q, idx_q, rd_byte;
  logic rw_q, m_ack, oe_q;

  // named internal events
  logic bus_ctl, byte_done, byte_ack, load_tx, wr_fire;

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .any_edge(any_edge)
  );

  smb_timeout #(.TO_CYC(TO_CYC)) u_to (
    .clk(clk), .rst_n(rst_n), .en(to_en), .busy(state != ST_IDLE),
    .activity(any_edge), .hit(to_hit)
  );

  smb_regfile #(
    .NREG(NREG), .CRIT_MASK(CRIT_MASK), .CMD_CFG(CMD_CFG),
    .CMD_LOCK(CMD_LOCK), .CMD_BLK(CMD_BLK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .wcmd(cmd_q), .widx(idx_q),
    .wdata(sh), .rcmd(cmd_q), .ridx(idx_q), .rd_byte(rd_byte), .to_en(to_en)
  );

  assign bus_ctl   = to_hit | stop_det | start_det;
  assign byte_done = (state == ST_RX) && scl_fall && (bcnt == 4'd8);
  assign byte_ack  = (kind != K_ADDR) || addr_match(sh, DEV_ADDR);
  assign load_tx   = scl_fall && (((state == ST_RX_ACK) && (kind == K_ADDR) && rw_q) ||
                                  ((state == ST_TX_ACK) && m_ack));
  assign wr_fire   = byte_done && (kind == K_DATA) && !bus_ctl;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      kind  <= K_ADDR;
      sh    <= '0;
      tx_sh <= '0;
      bcnt  <= '0;
      cmd_q <= '0;
      idx_q <= '0;
      rw_q  <= 1'b0;
      m_ack <= 1'b0;
      oe_q  <= 1'b0;
    end else if (to_hit || stop_det) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else if (start_det) begin
      state <= ST_RX;
      kind  <= K_ADDR;
      bcnt  <= '0;
      oe_q  <= 1'b0;
    end else if (load_tx) begin
      state <= ST_TX;
      tx_sh <= rd_byte[6:0];
      oe_q  <= ~rd_byte[7];
      bcnt  <= '0;
      idx_q <= idx_next(idx_q);
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
          end else if (byte_done) begin
            bcnt <= '0;
            if (byte_ack) begin
              state <= ST_RX_ACK;
              oe_q  <= 1'b1;
              case (kind)
                K_ADDR: begin rw_q <= sh[0]; idx_q <= '0; end
                K_CMD:  begin cmd_q <= sh;   idx_q <= '0; end
                default: idx_q <= idx_next(idx_q);
              endcase
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            state <= ST_RX;
            oe_q  <= 1'b0;
            kind  <= (kind == K_ADDR) ? K_CMD : K_DATA;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bcnt == 4'd7) begin
              state <= ST_TX_ACK;
              oe_q  <= 1'b0;
            end else begin
              oe_q  <= ~tx_sh[6];
              tx_sh <= {tx_sh[5:0], 1'b0};
              bcnt  <= bcnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  AST_OWN_ADDR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && kind == K_ADDR && addr_match(sh, DEV_ADDR) && !bus_ctl) |=> sda_oe); // R1

  AST_FOREIGN_ADDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && kind == K_ADDR && !addr_match(sh, DEV_ADDR) && !bus_ctl)
      |=> (state == ST_IDLE && !sda_oe)); // R1

  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX_ACK && scl_fall && !m_ack && !bus_ctl)
      |=> (state == ST_IDLE && !sda_oe)); // R4

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R4

  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> (state == ST_IDLE && !sda_oe)); // R6

endmodule

// File: tb/tb_smb_slave_engine.sv
module tb_smb_slave_engine;

  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h40;
  localparam int TO_WAIT = 400; // timeout is 10 kHz * 35 = 350 cycles

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  smb_slave_engine #(.CLK_KHZ(10), .TIMEOUT_MS(35)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit mon_en = 1'b0;
  logic [7:0] mon_sh = '0;
  int mon_n = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // monitor: assembles slave-driven bytes and compares with the scoreboard
  always @(posedge m_scl) begin
    if (mon_en) begin
      mon_sh = {mon_sh[6:0], sda_line};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL scoreboard: actual 0x%0h expected none", mon_sh);
        end else begin
          check(tag_q.pop_front(), int'(mon_sh), int'(exp_q.pop_front()));
        end
      end
    end
  end

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hq();
    m_scl = 1'b1; hq();
    m_sda = 1'b0; hq();
    m_scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hq();
    m_scl = 1'b1; hq();
    m_sda = 1'b1; hq();
  endtask

  task automatic write_bit(input logic b);
    m_sda = b; hq();
    m_scl = 1'b1; hq(); hq();
    m_scl = 1'b0; hq();
  endtask

  task automatic read_bit(output logic b);
    m_sda = 1'b1; hq();
    m_scl = 1'b1; hq();
    b = sda_line; hq();
    m_scl = 1'b0; hq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) write_bit(v[i]);
    read_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack);
    logic b;
    mon_en = 1'b1;
    for (int i = 0; i < 8; i++) read_bit(b);
    mon_en = 1'b0;
    write_bit(~give_ack);
  endtask

  task automatic txn_write(input logic [7:0] cmd, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, input string req);
    logic ack;
    bus_start();
    send_byte({ADDR, 1'b0}, ack); check({req, " addr ack"}, ack, 1);
    send_byte(cmd, ack);          check({req, " cmd ack"}, ack, 1);
    send_byte(d0, ack);           check({req, " data0 ack"}, ack, 1);
    if (n > 1) begin
      send_byte(d1, ack);         check({req, " data1 ack"}, ack, 1);
    end
    bus_stop();
  endtask

  task automatic txn_read(input logic [7:0] cmd, input int n, input string req);
    logic ack;
    bus_start();
    send_byte({ADDR, 1'b0}, ack); check({req, " addr-w ack"}, ack, 1);
    send_byte(cmd, ack);          check({req, " cmd ack"}, ack, 1);
    bus_start();
    send_byte({ADDR, 1'b1}, ack); check({req, " R1 repeated-start addr-r ack"}, ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1);
    bus_stop();
  endtask

  // stall with the slave holding its address acknowledge low
  task automatic stall_on_ack(input string req, input int exp_after);
    for (int i = 7; i >= 0; i--) write_bit(i == 0 ? 1'b0 : ADDR[i-1]);
    hq();
    check({req, " ack driven before stall"}, sda_oe, 1);
    repeat (TO_WAIT) @(negedge clk);
    check({req, " sda_oe after quiet bus"}, sda_oe, exp_after);
  endtask

  initial begin
    logic ack;
    logic b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    check("R10 sda_oe after reset", sda_oe, 0);
    expect_byte(8'h00, "R10 word0 low after reset");
    expect_byte(8'h00, "R10 word0 high after reset");
    txn_read(8'h00, 2, "R10");
    expect_byte(8'h00, "R10 cfg after reset");
    txn_read(8'hD1, 1, "R10");

    // R2 writes
    txn_write(8'h00, 2, 8'h34, 8'h12, "R2 w0");
    txn_write(8'h01, 2, 8'h5A, 8'hA5, "R2 w1");
    txn_write(8'h02, 2, 8'h0E, 8'h0F, "R2 w2");
    txn_write(8'h03, 2, 8'h88, 8'h77, "R2 w3");

    // R3 word read, low byte first
    expect_byte(8'h5A, "R3 word1 low");
    expect_byte(8'hA5, "R3 word1 high");
    txn_read(8'h01, 2, "R3");

    // R9 filler past the word
    expect_byte(8'h34, "R2 word0 low");
    expect_byte(8'h12, "R2 word0 high");
    expect_byte(8'hFF, "R9 byte past word");
    txn_read(8'h00, 3, "R9");

    // R1 foreign address is not acknowledged
    bus_start();
    send_byte({7'h22, 1'b0}, ack);
    check("R1 foreign address nack", ack, 0);
    bus_stop();

    // R5 block read with trailing filler
    expect_byte(8'h08, "R5 block count");
    expect_byte(8'h34, "R5 blk w0 lo"); expect_byte(8'h12, "R5 blk w0 hi");
    expect_byte(8'h5A, "R5 blk w1 lo"); expect_byte(8'hA5, "R5 blk w1 hi");
    expect_byte(8'h0E, "R5 blk w2 lo"); expect_byte(8'h0F, "R5 blk w2 hi");
    expect_byte(8'h88, "R5 blk w3 lo"); expect_byte(8'h77, "R5 blk w3 hi");
    expect_byte(8'hFF, "R9 byte past block");
    txn_read(8'h30, 10, "R5");

    // R4 early NACK: next byte (0x12) would pull SDA low on its first bit
    bus_start();
    send_byte({ADDR, 1'b0}, ack); check("R4 addr-w ack", ack, 1);
    send_byte(8'h30, ack);        check("R4 cmd ack", ack, 1);
    bus_start();
    send_byte({ADDR, 1'b1}, ack); check("R4 addr-r ack", ack, 1);
    expect_byte(8'h08, "R4 count before nack");
    expect_byte(8'h34, "R4 byte before nack");
    recv_byte(1'b1);
    recv_byte(1'b0);
    check("R4 sda_oe after nack", sda_oe, 0);
    read_bit(b); check("R4 line high after nack bit0", b, 1);
    read_bit(b); check("R4 line high after nack bit1", b, 1);
    bus_stop();

    // R6 timeout disabled: slave keeps its acknowledge
    bus_start();
    stall_on_ack("R6 disabled", 1);
    read_bit(b);
    bus_stop();

    // R6 enable and read back
    txn_write(8'hD1, 1, 8'h08, 8'h00, "R6 cfg");
    expect_byte(8'h08, "R6 cfg low readback");
    expect_byte(8'h00, "R9 cfg high byte");
    txn_read(8'hD1, 2, "R6");

    // R6 timeout enabled: slave releases the bus
    bus_start();
    stall_on_ack("R6 enabled", 0);
    bus_stop();
    expect_byte(8'h5A, "R6 slave usable after timeout");
    txn_read(8'h01, 1, "R6");

    // R7 lock set and sticky
    txn_write(8'hD0, 1, 8'h01, 8'h00, "R7 set lock");
    expect_byte(8'h01, "R7 lock reads set");
    txn_read(8'hD0, 1, "R7");
    txn_write(8'hD0, 1, 8'h00, 8'h00, "R7 clear attempt");
    expect_byte(8'h01, "R7 lock still set");
    txn_read(8'hD0, 1, "R7");

    // R8 critical write dropped, non-critical still written
    txn_write(8'h02, 2, 8'hEF, 8'hBE, "R8 critical write ack");
    expect_byte(8'h0E, "R8 word2 low kept");
    expect_byte(8'h0F, "R8 word2 high kept");
    txn_read(8'h02, 2, "R8");
    txn_write(8'h00, 2, 8'hFE, 8'hCA, "R8 open write ack");
    expect_byte(8'hFE, "R8 word0 low written");
    expect_byte(8'hCA, "R8 word0 high written");
    txn_read(8'h00, 2, "R8");

    check("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule